// File: doc/BRIEF.md
# General Purpose Up-Counting Timer

This block is a timer core with a word-addressed register port. A free-running up-counter advances on every clock, or on every 2^(v+1)-th clock when the power-of-two prescaler is on. When it passes its all-ones value, it either reloads from a load register or returns to zero and stops. A match register can raise a compare event. An input pin can be sampled on selected edges into one capture register, or alternately into two. An output pin can pulse or toggle on overflow, or on overflow and compare.

Each of the three events (match, overflow, capture) sets a sticky status flag. A flag is cleared by writing a one to it, and a single interrupt line is raised while any enabled flag is set. Software writes the counter directly, or forces a reload from the load register by writing any value to the reload trigger address. Clock selection, bus protocol and clock-domain crossing of writes belong to the surrounding logic.

Top module: `gpt_timer_core`

## Requirements
- R1: Registers sit at word addresses 0 control, 1 counter, 2 load, 3 reload trigger (write only), 4 match, 5 capture A, 6 capture B, 7 status, 8 interrupt enable. After reset every one of them reads zero, and pwm_out, pwm_oe and irq are low.
- R2: While control bit 0 is set, the counter rises by one per tick, and a tick comes on every clock when the prescaler is off. While bit 0 is clear, the counter holds. A control write takes effect from the clock after it.
- R3: Control bit 5 turns the prescaler on, and the 3-bit value v in control bits 4:2 then makes a tick every 2^(v+1) clocks. The first tick comes 2^(v+1) clocks after the control write.
- R4: A tick at the all-ones count with control bit 1 set loads the counter from the load register, and sets status bit 1 (overflow).
- R5: A tick at the all-ones count with control bit 1 clear sets the counter to zero, clears control bit 0, and sets status bit 1.
- R6: With control bit 6 set, a tick that makes the counter equal to the match register sets status bit 0 (match). With bit 6 clear, no match flag is raised.
- R7: Control bits 9:8 pick the capture edges of cap_in: 01 rising, 10 falling, 11 both, 00 none. A selected edge stores the current count in capture A and sets status bit 2.
- R8: With control bit 13 set, selected edges fill capture A and then capture B in turn, and status bit 2 is set only on the capture B store. A control write restarts the pairing at capture A. With bit 13 clear, capture B is never written.
- R9: Control bits 11:10 pick the output trigger: 00 none, 01 overflow, 10 overflow or match. Control bit 7 is the idle level of pwm_out. With bit 12 clear, each trigger inverts pwm_out for exactly the one clock after the event.
- R10: With control bit 12 set, pwm_out toggles after each trigger. A control write returns pwm_out to the idle level.
- R11: Writing status clears the bits written as one and leaves the others. A flag set in the same clock wins. irq is high while some status bit and the same interrupt enable bit are both set.
- R12: A counter write loads the written value, and a write to the reload trigger loads the load register. Either write takes priority over a tick in the same clock and raises no events.
- R13: pwm_oe follows control bit 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | CNT_W | Combinational read data |
| cap_in | input | 1 | Capture input, synchronous to clk |
| pwm_out | output | 1 | Pulse / toggle output |
| pwm_oe | output | 1 | Output pin direction |
| irq | output | 1 | Combined interrupt request |

## Verification
Two paths are hard to reach from the ports: the wrap at the all-ones count, and its overlap with a compare hit inside one reload period. Waiting for a 32-bit counter to wrap is out of reach. The stimulus therefore writes the counter a few counts below all ones and sets the load and match registers near the top of the range. Overflow, reload, match and the output reaction then fall within a handful of clocks, and every expected value is known to the clock. Paired capture is driven with the counter stopped and rewritten between edges, so each store is tied to a distinct value.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

   localparam int GPT_AW    = 4;
   localparam int GPT_PSC_W = 3;

   typedef enum logic [GPT_AW-1:0] {
      RA_CTRL   = 4'd0,
      RA_COUNT  = 4'd1,
      RA_LOAD   = 4'd2,
      RA_RELOAD = 4'd3,
      RA_MATCH  = 4'd4,
      RA_CAPA   = 4'd5,
      RA_CAPB   = 4'd6,
      RA_STATUS = 4'd7,
      RA_IRQEN  = 4'd8
   } gpt_reg_e;

   // Packed to match the control word layout, most significant field first.
   typedef struct packed {
      logic                 out_dir;   // 14
      logic                 cap_pair;  // 13
      logic                 toggle;    // 12
      logic [1:0]           trg_sel;   // 11:10
      logic [1:0]           cap_sel;   // 9:8
      logic                 idle_lvl;  // 7
      logic                 cmp_en;    // 6
      logic                 psc_en;    // 5
      logic [GPT_PSC_W-1:0] psc_val;   // 4:2
      logic                 autold;    // 1
      logic                 run;       // 0
   } gpt_ctrl_t;

   localparam int GPT_CTRL_W = $bits(gpt_ctrl_t);

   // Status / enable bit positions.
   localparam int ST_MATCH = 0;
   localparam int ST_OVF   = 1;
   localparam int ST_CAP   = 2;
   localparam int ST_W     = 3;

endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
   parameter int VAL_W   = 3,
   parameter bit USE_PSC = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             psc_en,
   input  logic [VAL_W-1:0] psc_val,
   input  logic             restart,
   output logic             tick
);
   localparam int DIV_W = 1 << VAL_W;

   if (VAL_W < 1 || VAL_W > 4) begin : g_bad_val_w
      $error("gpt_prescaler: VAL_W out of range");
   end

   if (USE_PSC) begin : g_psc
      logic [DIV_W-1:0] div_q;
      logic [DIV_W-1:0] mask;

      always_comb begin
         mask = '0;
         for (int i = 0; i < DIV_W; i++) begin
            if (i <= int'(psc_val)) mask[i] = 1'b1;
         end
      end

      assign tick = run & (~psc_en | ((div_q & mask) == mask));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       div_q <= '0;
         else if (restart) div_q <= '0;
         else if (run)     div_q <= div_q + DIV_W'(1);
      end
   end else begin : g_nopsc
      assign tick = run;
   end

   // R3: no tick can come while the counter is stopped
   p_idle_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !tick);

endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_we,
   input  logic             trig_we,
   input  logic [CNT_W-1:0] wdata,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] match_val,
   input  logic             autold,
   input  logic             cmp_en,
   output logic [CNT_W-1:0] count,
   output logic             ovf_evt,
   output logic             match_evt
);
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] step_val;
   logic             at_max;
   logic             upd;

   always_comb begin
      at_max    = (count_q == '1);
      upd       = tick & ~cnt_we & ~trig_we;
      ovf_evt   = upd & at_max;
      step_val  = at_max ? (autold ? load_val : '0) : count_q + CNT_W'(1);
      match_evt = upd & cmp_en & (step_val == match_val);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count_q <= '0;
      else if (cnt_we)  count_q <= wdata;
      else if (trig_we) count_q <= load_val;
      else if (tick)    count_q <= step_val;
   end

   assign count = count_q;

   // R2: without tick or write, the count holds
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !cnt_we && !trig_we) |=> $stable(count_q));

   // R4: wrap with auto-reload takes the load value
   p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_evt && autold) |=> count_q == $past(load_val));

   // R5: wrap without auto-reload lands on zero
   p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_evt && !autold) |=> count_q == '0);

   // R12: a direct counter write lands unchanged
   p_cnt_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |=> count_q == $past(wdata));

endmodule

// File: rtl/gpt_capture.sv
module gpt_capture #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_in,
   input  logic [1:0]       cap_sel,
   input  logic             pair,
   input  logic             restart,
   input  logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] cap_a,
   output logic [CNT_W-1:0] cap_b,
   output logic             cap_evt
);
   logic prev_q;
   logic second_q;
   logic hit;
   logic to_b;

   always_comb begin
      hit     = (cap_sel[0] & cap_in & ~prev_q) | (cap_sel[1] & ~cap_in & prev_q);
      to_b    = pair & second_q;
      cap_evt = hit & (~pair | second_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= 1'b0;
         second_q <= 1'b0;
         cap_a    <= '0;
         cap_b    <= '0;
      end else begin
         prev_q <= cap_in;
         if (restart)          second_q <= 1'b0;
         else if (hit && pair) second_q <= ~second_q;
         if (hit && !to_b)     cap_a <= count;
         if (hit && to_b)      cap_b <= count;
      end
   end

   // R7: code 00 leaves both capture registers untouched
   p_cap_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_sel == 2'b00) |=> ($stable(cap_a) && $stable(cap_b)));

   // R8: single mode never writes capture B
   p_single_no_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !pair |=> $stable(cap_b));

endmodule

// File: rtl/gpt_output.sv
module gpt_output (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] trg_sel,
   input  logic       toggle,
   input  logic       idle_lvl,
   input  logic       dir_cfg,
   input  logic       restart,
   input  logic       ovf_evt,
   input  logic       match_evt,
   output logic       pwm_out,
   output logic       pwm_oe
);
   logic phase_q;
   logic fire;

   always_comb begin
      unique case (trg_sel)
         2'b01:   fire = ovf_evt;
         2'b10:   fire = ovf_evt | match_evt;
         default: fire = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              phase_q <= 1'b0;
      else if (restart)        phase_q <= 1'b0;
      else if (trg_sel == '0)  phase_q <= 1'b0;
      else if (toggle)         phase_q <= phase_q ^ fire;
      else                     phase_q <= fire;
   end

   assign pwm_out = idle_lvl ^ phase_q;
   assign pwm_oe  = dir_cfg;

   // R9: with no trigger selected the pin rests at the idle level
   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (trg_sel == 2'b00 && !restart) |=> (pwm_out == idle_lvl));

   // R9: a pulse lasts one clock, so no event means idle level next clock
   p_pulse_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!toggle && !restart && !ovf_evt && !match_evt) |=> (pwm_out == idle_lvl));

endmodule

// File: rtl/gpt_timer_core.sv
module gpt_timer_core
   import gpt_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter bit USE_PSC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [GPT_AW-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [GPT_AW-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   input  logic              cap_in,
   output logic              pwm_out,
   output logic              pwm_oe,
   output logic              irq
);
   if (CNT_W < GPT_CTRL_W || CNT_W > 64) begin : g_bad_cnt_w
      $error("gpt_timer_core: CNT_W must hold the control word and be at most 64");
   end

   gpt_ctrl_t        ctrl_q;
   logic [CNT_W-1:0] load_q;
   logic [CNT_W-1:0] match_q;
   logic [ST_W-1:0]  status_q;
   logic [ST_W-1:0]  irqen_q;

   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] cap_a;
   logic [CNT_W-1:0] cap_b;
   logic             tick;
   logic             ovf_evt;
   logic             match_evt;
   logic             cap_evt;

   logic ctrl_we, cnt_we, load_we, trig_we, match_we, status_we, irqen_we;
   logic [ST_W-1:0] set_vec;
   logic [ST_W-1:0] clr_vec;

   always_comb begin
      ctrl_we   = wr_en && (gpt_reg_e'(wr_addr) == RA_CTRL);
      cnt_we    = wr_en && (gpt_reg_e'(wr_addr) == RA_COUNT);
      load_we   = wr_en && (gpt_reg_e'(wr_addr) == RA_LOAD);
      trig_we   = wr_en && (gpt_reg_e'(wr_addr) == RA_RELOAD);
      match_we  = wr_en && (gpt_reg_e'(wr_addr) == RA_MATCH);
      status_we = wr_en && (gpt_reg_e'(wr_addr) == RA_STATUS);
      irqen_we  = wr_en && (gpt_reg_e'(wr_addr) == RA_IRQEN);
      set_vec          = '0;
      set_vec[ST_MATCH] = match_evt;
      set_vec[ST_OVF]   = ovf_evt;
      set_vec[ST_CAP]   = cap_evt;
      clr_vec = status_we ? wr_data[ST_W-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         load_q   <= '0;
         match_q  <= '0;
         status_q <= '0;
         irqen_q  <= '0;
      end else begin
         if (ctrl_we)                        ctrl_q     <= gpt_ctrl_t'(wr_data[GPT_CTRL_W-1:0]);
         else if (ovf_evt && !ctrl_q.autold) ctrl_q.run <= 1'b0;
         if (load_we)  load_q  <= wr_data;
         if (match_we) match_q <= wr_data;
         if (irqen_we) irqen_q <= wr_data[ST_W-1:0];
         status_q <= (status_q & ~clr_vec) | set_vec;
      end
   end

   gpt_prescaler #(.VAL_W(GPT_PSC_W), .USE_PSC(USE_PSC)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl_q.run),
      .psc_en  (ctrl_q.psc_en),
      .psc_val (ctrl_q.psc_val),
      .restart (ctrl_we | cnt_we | trig_we),
      .tick    (tick)
   );

   gpt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .cnt_we    (cnt_we),
      .trig_we   (trig_we),
      .wdata     (wr_data),
      .load_val  (load_q),
      .match_val (match_q),
      .autold    (ctrl_q.autold),
      .cmp_en    (ctrl_q.cmp_en),
      .count     (count),
      .ovf_evt   (ovf_evt),
      .match_evt (match_evt)
   );

   gpt_capture #(.CNT_W(CNT_W)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_in  (cap_in),
      .cap_sel (ctrl_q.cap_sel),
      .pair    (ctrl_q.cap_pair),
      .restart (ctrl_we),
      .count   (count),
      .cap_a   (cap_a),
      .cap_b   (cap_b),
      .cap_evt (cap_evt)
   );

   gpt_output u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .trg_sel   (ctrl_q.trg_sel),
      .toggle    (ctrl_q.toggle),
      .idle_lvl  (ctrl_q.idle_lvl),
      .dir_cfg   (ctrl_q.out_dir),
      .restart   (ctrl_we),
      .ovf_evt   (ovf_evt),
      .match_evt (match_evt),
      .pwm_out   (pwm_out),
      .pwm_oe    (pwm_oe)
   );

   always_comb begin
      unique case (gpt_reg_e'(rd_addr))
         RA_CTRL:   rd_data = CNT_W'(ctrl_q);
         RA_COUNT:  rd_data = count;
         RA_LOAD:   rd_data = load_q;
         RA_MATCH:  rd_data = match_q;
         RA_CAPA:   rd_data = cap_a;
         RA_CAPB:   rd_data = cap_b;
         RA_STATUS: rd_data = CNT_W'(status_q);
         RA_IRQEN:  rd_data = CNT_W'(irqen_q);
         default:   rd_data = '0;
      endcase
   end

   assign irq = |(status_q & irqen_q);

   // R5: a wrap without auto-reload stops the counter
   p_autostop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_evt && !ctrl_q.autold && !ctrl_we) |=> !ctrl_q.run);

   // R11: a status write with no new event clears exactly the ones written
   p_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (status_we && set_vec == '0) |=> status_q == ($past(status_q) & ~$past(wr_data[ST_W-1:0])));

endmodule

// File: tb/test_gpt_timer_core.sv
`timescale 1ns/100ps
module test_gpt_timer_core;

   localparam int A_CTRL = 0, A_CNT = 1, A_LOAD = 2, A_TRIG = 3, A_MATCH = 4,
                  A_CAPA = 5, A_CAPB = 6, A_STAT = 7, A_IRQEN = 8;
   localparam int K_REG = 0, K_PWM = 1, K_IRQ = 2, K_OE = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        cap_in = 1'b0;
   logic        pwm_out, pwm_oe, irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb_q[$];
   event  sample_ev;

   always #10 clk = ~clk;

   gpt_timer_core i_gpt_timer_core (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .cap_in(cap_in),
      .pwm_out(pwm_out), .pwm_oe(pwm_oe), .irq(irq)
   );

   // Monitor: pops expected items and compares with what the design shows.
   initial begin
      forever begin
         @(sample_ev);
         while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it = sb_q.pop_front();
            case (it.kind)
               K_PWM:   got = {31'd0, pwm_out};
               K_IRQ:   got = {31'd0, irq};
               K_OE:    got = {31'd0, pwm_oe};
               default: got = rd_data;
            endcase
            n_tests++;
            if (got !== it.exp) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", it.tag, got, it.exp);
            end
         end
      end
   end

   task automatic push_item(input int kind, input logic [31:0] exp, input string tag);
      item_t it;
      it.kind = kind; it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
      -> sample_ev;
      wait (sb_q.size() == 0);
   endtask

   task automatic chk_reg(input int a, input logic [31:0] exp, input string tag);
      rd_addr = 4'(a);
      #0.1;
      push_item(K_REG, exp, tag);
   endtask

   task automatic chk_pin(input int kind, input logic exp, input string tag);
      #0.1;
      push_item(kind, {31'd0, exp}, tag);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (2000) @(negedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int a = 0; a <= 8; a++) chk_reg(a, 32'h0, "R1 reg after reset");
      chk_pin(K_PWM, 1'b0, "R1 pwm_out");
      chk_pin(K_IRQ, 1'b0, "R1 irq");
      chk_pin(K_OE, 1'b0, "R1 pwm_oe");

      // R2: start, count, stop
      wr(A_CNT, 32'd100);
      wr(A_CTRL, 32'h1);
      chk_reg(A_CNT, 32'd100, "R2 no tick on start write");
      tick(5);
      chk_reg(A_CNT, 32'd105, "R2 one per clock");
      wr(A_CTRL, 32'h0);
      tick(3);
      chk_reg(A_CNT, 32'd106, "R2 holds when stopped");

      // R3: prescaler v=1, divide by 4
      wr(A_CNT, 32'd0);
      wr(A_CTRL, 32'h1 | (32'h1 << 5) | (32'h1 << 2));
      tick(3);
      chk_reg(A_CNT, 32'd0, "R3 no tick before 4 clocks");
      tick(1);
      chk_reg(A_CNT, 32'd1, "R3 first tick");
      tick(4);
      chk_reg(A_CNT, 32'd2, "R3 second tick");
      wr(A_CTRL, 32'h0);

      // R4: overflow with auto-reload
      wr(A_LOAD, 32'h10);
      wr(A_CNT, 32'hFFFF_FFFE);
      wr(A_CTRL, 32'h3);
      tick(1);
      chk_reg(A_CNT, 32'hFFFF_FFFF, "R4 at max");
      chk_reg(A_STAT, 32'h0, "R4 no flag yet");
      tick(1);
      chk_reg(A_CNT, 32'h10, "R4 reloaded");
      chk_reg(A_STAT, 32'h2, "R4 overflow flag");
      chk_pin(K_PWM, 1'b0, "R9 no trigger no output");
      wr(A_CTRL, 32'h0);
      wr(A_STAT, 32'h2);
      chk_reg(A_STAT, 32'h0, "R11 overflow flag cleared");

      // R5: overflow without auto-reload
      wr(A_CNT, 32'hFFFF_FFFF);
      wr(A_CTRL, 32'h1);
      tick(1);
      chk_reg(A_CNT, 32'h0, "R5 wraps to zero");
      chk_reg(A_CTRL, 32'h0, "R5 start bit cleared");
      chk_reg(A_STAT, 32'h2, "R5 overflow flag");
      tick(2);
      chk_reg(A_CNT, 32'h0, "R5 stays stopped");
      wr(A_STAT, 32'h7);

      // R6: compare
      wr(A_MATCH, 32'd5);
      wr(A_CNT, 32'd2);
      wr(A_CTRL, 32'h1 | (32'h1 << 6));
      tick(2);
      chk_reg(A_STAT, 32'h0, "R6 before match");
      tick(1);
      chk_reg(A_STAT, 32'h1, "R6 match flag");
      wr(A_CTRL, 32'h0);
      wr(A_STAT, 32'h1);
      wr(A_CNT, 32'd2);
      wr(A_CTRL, 32'h1);
      tick(5);
      chk_reg(A_STAT, 32'h0, "R6 no flag with compare off");
      wr(A_CTRL, 32'h0);

      // R11: interrupt enable and write-one-to-clear
      wr(A_IRQEN, 32'h2);
      wr(A_CNT, 32'hFFFF_FFFF);
      wr(A_CTRL, 32'h1);
      tick(1);
      chk_pin(K_IRQ, 1'b1, "R11 irq on enabled flag");
      wr(A_IRQEN, 32'h0);
      chk_pin(K_IRQ, 1'b0, "R11 irq masked");
      wr(A_IRQEN, 32'h2);
      wr(A_STAT, 32'h1);
      chk_reg(A_STAT, 32'h2, "R11 other bit untouched");
      wr(A_STAT, 32'h2);
      chk_reg(A_STAT, 32'h0, "R11 flag cleared");
      chk_pin(K_IRQ, 1'b0, "R11 irq drops");
      wr(A_IRQEN, 32'h0);

      // R12: trigger reload and write priority
      wr(A_LOAD, 32'h1234);
      wr(A_TRIG, 32'hDEAD);
      chk_reg(A_CNT, 32'h1234, "R12 trigger reload");
      wr(A_CTRL, 32'h1);
      wr(A_CNT, 32'h500);
      chk_reg(A_CNT, 32'h500, "R12 write beats tick");
      tick(2);
      chk_reg(A_CNT, 32'h502, "R12 counts after write");
      wr(A_TRIG, 32'h0);
      chk_reg(A_CNT, 32'h1234, "R12 trigger while running");
      wr(A_CTRL, 32'h0);

      // R7: capture edge select
      wr(A_CNT, 32'h55);
      wr(A_CTRL, 32'h100);
      cap_in = 1'b1; tick(1);
      chk_reg(A_CAPA, 32'h55, "R7 rising capture");
      chk_reg(A_STAT, 32'h4, "R7 capture flag");
      wr(A_STAT, 32'h4);
      wr(A_CNT, 32'h66);
      cap_in = 1'b0; tick(1);
      chk_reg(A_CAPA, 32'h55, "R7 falling ignored in rising mode");
      chk_reg(A_STAT, 32'h0, "R7 no flag on ignored edge");
      wr(A_CTRL, 32'h200);
      cap_in = 1'b1; tick(1);
      chk_reg(A_STAT, 32'h0, "R7 rising ignored in falling mode");
      cap_in = 1'b0; tick(1);
      chk_reg(A_CAPA, 32'h66, "R7 falling capture");
      chk_reg(A_STAT, 32'h4, "R7 falling flag");
      wr(A_STAT, 32'h4);
      wr(A_CTRL, 32'h0);
      wr(A_CNT, 32'h77);
      cap_in = 1'b1; tick(1);
      cap_in = 1'b0; tick(1);
      chk_reg(A_STAT, 32'h0, "R7 code 00 no flag");
      chk_reg(A_CAPA, 32'h66, "R7 code 00 no capture");
      wr(A_CTRL, 32'h300);
      cap_in = 1'b1; tick(1);
      chk_reg(A_CAPA, 32'h77, "R7 both edges");
      chk_reg(A_STAT, 32'h4, "R7 both edges flag");

      // R8: paired capture
      wr(A_STAT, 32'h4);
      wr(A_CNT, 32'h11);
      wr(A_CTRL, 32'h2300);
      cap_in = 1'b0; tick(1);
      chk_reg(A_CAPA, 32'h11, "R8 first edge to A");
      chk_reg(A_CAPB, 32'h0, "R8 B untouched");
      chk_reg(A_STAT, 32'h0, "R8 no flag after first");
      wr(A_CNT, 32'h22);
      cap_in = 1'b1; tick(1);
      chk_reg(A_CAPB, 32'h22, "R8 second edge to B");
      chk_reg(A_CAPA, 32'h11, "R8 A kept");
      chk_reg(A_STAT, 32'h4, "R8 flag after second");
      wr(A_CNT, 32'h33);
      cap_in = 1'b0; tick(1);
      chk_reg(A_CAPA, 32'h33, "R8 third edge back to A");
      chk_reg(A_CAPB, 32'h22, "R8 B kept");
      wr(A_CTRL, 32'h0);
      wr(A_STAT, 32'h7);

      // R9: pulse on overflow
      wr(A_LOAD, 32'hFFFF_FFFC);
      wr(A_CNT, 32'hFFFF_FFFE);
      wr(A_CTRL, 32'h403);
      chk_pin(K_PWM, 1'b0, "R9 idle low");
      tick(1);
      chk_pin(K_PWM, 1'b0, "R9 before overflow");
      tick(1);
      chk_pin(K_PWM, 1'b1, "R9 pulse after overflow");
      tick(1);
      chk_pin(K_PWM, 1'b0, "R9 pulse one clock");
      tick(3);
      chk_pin(K_PWM, 1'b1, "R9 second pulse");
      wr(A_CTRL, 32'h0);
      // R9: overflow or match, idle high
      wr(A_MATCH, 32'hFFFF_FFFD);
      wr(A_CNT, 32'hFFFF_FFFC);
      wr(A_CTRL, 32'h8C3);
      chk_pin(K_PWM, 1'b1, "R9 idle high");
      tick(1);
      chk_pin(K_PWM, 1'b0, "R9 pulse on match");
      tick(1);
      chk_pin(K_PWM, 1'b1, "R9 back to idle");
      tick(2);
      chk_pin(K_PWM, 1'b0, "R9 pulse on overflow mode 2");
      tick(1);
      chk_pin(K_PWM, 1'b0, "R9 pulse on match after reload");
      wr(A_CTRL, 32'h80);
      chk_pin(K_PWM, 1'b1, "R9 no trigger idle high");
      wr(A_CTRL, 32'h0);
      wr(A_STAT, 32'h7);

      // R10: toggle mode
      wr(A_LOAD, 32'hFFFF_FFFE);
      wr(A_CNT, 32'hFFFF_FFFE);
      wr(A_CTRL, 32'h1403);
      chk_pin(K_PWM, 1'b0, "R10 start at idle");
      tick(1);
      chk_pin(K_PWM, 1'b0, "R10 before overflow");
      tick(1);
      chk_pin(K_PWM, 1'b1, "R10 toggled");
      tick(1);
      chk_pin(K_PWM, 1'b1, "R10 level held");
      tick(1);
      chk_pin(K_PWM, 1'b0, "R10 toggled back");
      wr(A_CTRL, 32'h0);

      // R13: output direction
      wr(A_CTRL, 32'h4000);
      chk_pin(K_OE, 1'b1, "R13 oe set");
      wr(A_CTRL, 32'h0);
      chk_pin(K_OE, 1'b0, "R13 oe clear");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule